// File: doc/BRIEF.md
# Dual Four-Bit Addressable Output Latch

Two separate four-bit output registers sit behind one shared two-bit bit-select address, one active-low write enable and one active-low clear. Each register has its own one-bit data input. The levels of the enable and the clear choose one of four modes on every cycle:

- **Addressed write**: one bit of each register takes its own data input and the other bits keep their values.
- **Hold**: every bit keeps its value.
- **Clear**: all bits of both registers go to zero.
- **Decode**: each register shows a one-of-four pattern. The addressed bit follows that register's data input and the other three bits are zero.

All inputs are sampled on the rising edge of a system clock, so the behaviour of a level-sensitive latch is modelled as a synchronous update. A synchronous active-high reset clears both registers, whatever level the clear input has. The widths are parameters. The default build has two groups of four bits.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: With `clr_n`=0 and `wr_en_n`=1 (clear mode), every bit of both groups is 0 after the edge.
- R3: With `clr_n`=1 and `wr_en_n`=0 (addressed write mode), the addressed bit of group g takes `din[g]`, and all other bits of that group keep their previous values.
- R4: Address value k selects bit k of each group: 0→bit 0, 1→bit 1, 2→bit 2, 3→bit 3. Bit i of group g appears on `q[g*4+i]`.
- R5: With `clr_n`=0 and `wr_en_n`=0 (decode mode), the addressed bit of group g equals `din[g]` and the other three bits of that group are 0. With data 1, addresses 0..3 give 0001, 0010, 0100 and 1000.
- R6: With `clr_n`=1 and `wr_en_n`=1 (hold mode), `q` is unchanged, whatever `sel_addr` and `din` do.
- R7: Group g is affected only by `din[g]`. Differing data bits give independent results in the two groups.
- R8: When the block goes from decode mode to addressed write mode, the decode pattern is the starting state for the writes.
- R9: `q` changes only at a rising clock edge. A new input value is first visible on `q` after the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_addr | input | 2 | Bit-select address, shared by both groups |
| wr_en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear, active low |
| din | input | 2 | Data bit per group; bit g feeds group g |
| q | output | 8 | Register outputs; group g on bits [g*4+3:g*4] |

## Verification
Every result of the block falls due exactly one rising edge after its inputs are applied, through a single register stage. This holds for clear, write, decode, hold and reset. The bench changes inputs on the falling edge. It first checks `q` one time unit later, before the next rising edge, and expects the old value. It then checks one time unit after the rising edge against a bench model updated for that edge. Directed walking-one and walking-zero write sequences, decode sweeps and the transition from decode to write come first. They are followed by repeated sweeps over all sixteen combinations of enable, clear and address, with random data for each group.

// File: rtl/al_pkg.sv
package al_pkg;
   typedef enum logic [1:0] {
      LM_HOLD  = 2'd0,
      LM_WRITE = 2'd1,
      LM_CLEAR = 2'd2,
      LM_DEMUX = 2'd3
   } lmode_e;
endpackage

// File: rtl/al_mode_decode.sv
module al_mode_decode
   import al_pkg::*;
#(
   parameter int GROUP_W = 4,
   localparam int ADDR_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1
)(
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en_n,
   input  logic               clr_n,
   output lmode_e             mode,
   output logic [GROUP_W-1:0] sel_oh
);
   always_comb begin
      unique case ({clr_n, wr_en_n})
         2'b11:   mode = LM_HOLD;
         2'b10:   mode = LM_WRITE;
         2'b01:   mode = LM_CLEAR;
         default: mode = LM_DEMUX;
      endcase
   end

   for (genvar i = 0; i < GROUP_W; i++) begin : g_sel
      assign sel_oh[i] = (addr == ADDR_W'(i));
   end

   always_comb begin
      assert ($onehot(sel_oh)); // R4
   end
endmodule

// File: rtl/al_bank.sv
module al_bank
   import al_pkg::*;
#(
   parameter int GROUP_W = 4
)(
   input  logic               clk,
   input  logic               rst,
   input  lmode_e             mode,
   input  logic [GROUP_W-1:0] sel_oh,
   input  logic               din,
   output logic [GROUP_W-1:0] q
);
   logic [GROUP_W-1:0] dmask;
   assign dmask = sel_oh & {GROUP_W{din}};

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         unique case (mode)
            LM_CLEAR: q <= '0;
            LM_WRITE: q <= (q & ~sel_oh) | dmask;
            LM_DEMUX: q <= dmask;
            default:  q <= q;
         endcase
      end
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      (mode == LM_CLEAR) |=> (q == '0)); // R2
   AST_WRITE_BIT: assert property (@(posedge clk) disable iff (rst)
      (mode == LM_WRITE) |=> ((q & $past(sel_oh)) == ($past(din) ? $past(sel_oh) : '0))); // R3
   AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst)
      (mode == LM_WRITE) |=> ((q & ~$past(sel_oh)) == ($past(q) & ~$past(sel_oh)))); // R3
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (mode == LM_HOLD) |=> $stable(q)); // R6
   AST_DEMUX_PATTERN: assert property (@(posedge clk) disable iff (rst)
      (mode == LM_DEMUX) |=> ($countones(q) == ($past(din) ? 1 : 0)) && ((q & ~$past(sel_oh)) == '0)); // R5
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
   import al_pkg::*;
#(
   parameter int NUM_GROUPS = 2,
   parameter int GROUP_W    = 4,
   localparam int ADDR_W    = (GROUP_W > 1) ? $clog2(GROUP_W) : 1,
   localparam int OUT_W     = NUM_GROUPS * GROUP_W
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     sel_addr,
   input  logic                  wr_en_n,
   input  logic                  clr_n,
   input  logic [NUM_GROUPS-1:0] din,
   output logic [OUT_W-1:0]      q
);
   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("NUM_GROUPS must be at least 1");
   end
   if (GROUP_W < 2 || GROUP_W != (1 << ADDR_W)) begin : g_bad_width
      $error("GROUP_W must be a power of two, at least 2");
   end

   lmode_e             mode;
   logic [GROUP_W-1:0] sel_oh;

   al_mode_decode #(.GROUP_W(GROUP_W)) u_dec (
      .addr    (sel_addr),
      .wr_en_n (wr_en_n),
      .clr_n   (clr_n),
      .mode    (mode),
      .sel_oh  (sel_oh)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
      logic [GROUP_W-1:0] bq;
      al_bank #(.GROUP_W(GROUP_W)) u_bank (
         .clk    (clk),
         .rst    (rst),
         .mode   (mode),
         .sel_oh (sel_oh),
         .din    (din[g]),
         .q      (bq)
      );
      assign q[g*GROUP_W +: GROUP_W] = bq;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (q == '0)); // R1
endmodule

// File: tb/sim_dual_addr_latch.sv
module sim_dual_addr_latch;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] sel_addr = 2'd0;
   logic       wr_en_n = 1'b1;
   logic       clr_n = 1'b1;
   logic [1:0] din = 2'd0;
   logic [7:0] q;

   int errors = 0;
   int checks = 0;
   logic [7:0] mdl = 8'h00;

   always #5 clk = ~clk;

   dual_addr_latch u0 (
      .clk(clk), .rst(rst), .sel_addr(sel_addr), .wr_en_n(wr_en_n),
      .clr_n(clr_n), .din(din), .q(q)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: q=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] next_model(input logic [7:0] cur, input logic [1:0] a,
                                             input logic en, input logic cl, input logic [1:0] d);
      logic [7:0] n = cur;
      for (int g = 0; g < 2; g++) begin
         case ({cl, en})
            2'b01: n[g*4 +: 4] = 4'b0000;
            2'b10: n[g*4 + a] = d[g];
            2'b00: n[g*4 +: 4] = d[g] ? (4'b0001 << a) : 4'b0000;
            default: ;
         endcase
      end
      return n;
   endfunction

   task automatic apply(input logic [1:0] a, input logic en, input logic cl,
                        input logic [1:0] d, input string req);
      @(negedge clk);
      sel_addr = a; wr_en_n = en; clr_n = cl; din = d;
      #1;
      check("R9 before edge", q, mdl);
      mdl = next_model(mdl, a, en, cl, d);
      @(posedge clk);
      #1;
      check(req, q, mdl);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; clr_n = 1'b1; wr_en_n = 1'b0; din = 2'b11; sel_addr = 2'd2;
      @(posedge clk);
      #1;
      mdl = 8'h00;
      check("R1 reset", q, 8'h00);
      @(negedge clk);
      rst = 1'b0; wr_en_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R4 R3: walking ones, then walking zeros, group A only
      for (int k = 0; k < 4; k++) apply(2'(k), 1'b0, 1'b1, 2'b01, "R3 R4 walking one");
      check("R3 pattern 1111", {4'b0000, q[3:0]}, 8'h0F);
      for (int k = 0; k < 4; k++) apply(2'(k), 1'b0, 1'b1, 2'b00, "R3 R4 walking zero");
      check("R3 pattern 0000", q, 8'h00);
      // R7: differing data per group
      apply(2'd1, 1'b0, 1'b1, 2'b10, "R7 group independence");
      apply(2'd3, 1'b0, 1'b1, 2'b01, "R7 group independence");
      check("R7 literal", q, 8'b0010_1000);
      // R6: hold with changing address and data
      for (int k = 0; k < 4; k++) apply(2'(k), 1'b1, 1'b1, 2'(k), "R6 hold");
      // R2: clear
      apply(2'd0, 1'b1, 1'b0, 2'b11, "R2 clear");
      check("R2 literal", q, 8'h00);
      // R5: decode sweep, data high on both groups
      for (int k = 0; k < 4; k++) begin
         apply(2'(k), 1'b0, 1'b0, 2'b11, "R5 decode");
         check("R5 literal", q, {2{4'b0001 << k}});
      end
      apply(2'd1, 1'b0, 1'b0, 2'b01, "R5 decode data mixed");
      // R8: leave decode into write, pattern kept
      apply(2'd2, 1'b0, 1'b0, 2'b11, "R8 decode setup");
      apply(2'd0, 1'b0, 1'b1, 2'b11, "R8 write after decode");
      check("R8 literal", q, 8'b0101_0101);
      // R1: reset from a nonzero state
      do_reset();
      // sweeps over all mode/address combinations with random data
      for (int rep = 0; rep < 40; rep++) begin
         for (int c = 0; c < 16; c++) begin
            logic [3:0] cc = 4'(c);
            string tag;
            case ({cc[2], cc[3]})
               2'b11: tag = "R6 sweep hold";
               2'b10: tag = "R3 sweep write";
               2'b01: tag = "R2 sweep clear";
               default: tag = "R5 sweep decode";
            endcase
            apply(cc[1:0], cc[3], cc[2], 2'($urandom), tag);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule